// File: doc/BRIEF.md
# Oversampling Ramp-Compare ADC Controller

This controller runs a ramp-compare analog-to-digital conversion against an external DAC and a one-bit comparator. Each conversion clears the DAC code to zero and raises it by one code per clock. The conversion ends when the comparator shows that the analog level is no longer above the DAC output. The code reached at that point is the sample.

One start request produces eight such conversions. The eight samples are summed in a 13-bit accumulator, and the sum is divided by eight with a fixed right shift, so no divider is needed. The resulting 10-bit average is loaded into a held output register, and a one-cycle completion pulse marks the load.

The comparator is asynchronous to the clock, so it passes through a two-flop synchronizer first. The DAC code is delayed by the same number of stages. A sample is therefore always paired with the comparator decision that belongs to it. After each clear, the ramp waits until both pipelines hold values for code zero before it takes its first step.

Top module: `ss_adc_avg`

## Requirements
- R1: While reset is held and right after it is released, `dac_code_o` is 0, `done_o` is 0 and `avg_o` is 0.
- R2: A comparator input of 1 means the analog level is above the DAC output. Each sample equals the lowest DAC code at which the comparator reads 0. If the comparator still reads 1 at code 1023, the sample is 1023.
- R3: Each accepted start runs exactly eight conversions. After every conversion, including the last one, `dac_code_o` returns from its ramp value to 0, so eight such returns occur before `done_o`.
- R4: `avg_o` equals the sum of the eight samples divided by eight, with the remainder dropped. Eight samples of 1023 give 1023, with no overflow.
- R5: `done_o` is high for exactly one clock, in the cycle in which the new `avg_o` first appears. `avg_o` holds its value in every cycle in which `done_o` is low.
- R6: `dac_code_o` changes only by rising one code or by clearing to 0, and it is 0 whenever the controller is idle.
- R7: A start pulse that arrives while conversions are in progress is ignored. The result and the number of conversions are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for one eight-sample averaged result; acted on only when idle |
| cmp_hi_i | input | 1 | Comparator output: 1 while the analog level is above the DAC output (asynchronous) |
| dac_code_o | output | 10 | Ramp code driven to the external DAC |
| done_o | output | 1 | One-cycle pulse when `avg_o` is updated |
| avg_o | output | 10 | Averaged conversion result |

## Verification
A wrong sample counter appears at the ports as the wrong number of returns of the DAC code to zero before `done_o`, for example seven instead of eight. Because the bench changes the comparator threshold for each conversion, the same fault also gives a wrong average, visible on the cycle `done_o` rises. A misaligned synchronizer or code delay shifts every sample by a code or more, and this shows in the first averaged result. A wrong ramp step or a missing clear breaks the +1-or-zero rule for `dac_code_o` in the very cycle it happens.

// File: rtl/ss_avg_pkg.sv
package ss_avg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CNV  = 2'd1,
    ST_ACC  = 2'd2
  } adc_state_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[0] <= 1'b0;
        else         ff_q[0] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[i] <= 1'b0;
        else         ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int W   = 10,
  parameter int LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] code_dly_o
);
  logic [W-1:0] code_q;
  logic [W-1:0] dly_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     code_q <= '0;
    else if (clr_i)  code_q <= '0;
    else if (step_i) code_q <= code_q + 1'b1;

  // delay line matches the comparator synchronizer depth
  for (genvar i = 0; i < LAT; i++) begin : g_dly
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dly_q[0] <= '0;
        else         dly_q[0] <= code_q;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) dly_q[i] <= '0;
        else         dly_q[i] <= dly_q[i-1];
    end
  end

  assign code_o     = code_q;
  assign code_dly_o = dly_q[LAT-1];
endmodule

// File: rtl/ss_accum.sv
module ss_accum #(
  parameter int W      = 10,
  parameter int N_LOG2 = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] smp_i,
  input  logic         add_i,
  output logic         last_o,
  output logic [W-1:0] avg_o,
  output logic         done_o
);
  localparam int ACC_W = W + N_LOG2;

  logic [W-1:0]      smp_q;
  logic [ACC_W-1:0]  acc_q, acc_nxt;
  logic [N_LOG2-1:0] cnt_q;
  logic [W-1:0]      avg_q;
  logic              done_q;

  assign acc_nxt = acc_q + ACC_W'(smp_q);
  assign last_o  = (cnt_q == {N_LOG2{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    smp_q <= '0;
    else if (cap_i) smp_q <= smp_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (add_i) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + 1'b1;   // counts 0..N-1, bumped after each add
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      avg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= add_i && last_o;
      if (add_i && last_o) avg_q <= acc_nxt[ACC_W-1:N_LOG2];
    end

  assign avg_o  = avg_q;
  assign done_o = done_q;
endmodule

// File: rtl/ss_adc_avg.sv
module ss_adc_avg
  import ss_avg_pkg::*;
#(
  parameter int DAC_W       = 10,
  parameter int SMP_LOG2    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_hi_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             done_o,
  output logic [DAC_W-1:0] avg_o
);
  localparam int          SET_W    = $clog2(SYNC_STAGES + 1);
  localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};

  adc_state_e       state_q, state_d;
  logic [SET_W-1:0] settle_q;
  logic             settle_clr, settle_inc, settled;
  logic             cmp_s;
  logic             dac_clr, dac_step;
  logic [DAC_W-1:0] code, code_dly;
  logic             acc_clr, acc_cap, acc_add, acc_last;

  ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_hi_i),
    .q_o   (cmp_s)
  );

  ss_ramp #(.W(DAC_W), .LAT(SYNC_STAGES)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (dac_clr),
    .step_i    (dac_step),
    .code_o    (code),
    .code_dly_o(code_dly)
  );

  ss_accum #(.W(DAC_W), .N_LOG2(SMP_LOG2)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (acc_clr),
    .cap_i (acc_cap),
    .smp_i (code_dly),
    .add_i (acc_add),
    .last_o(acc_last),
    .avg_o (avg_o),
    .done_o(done_o)
  );

  assign settled = (settle_q == SET_W'(SYNC_STAGES));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         settle_q <= '0;
    else if (settle_clr) settle_q <= '0;
    else if (settle_inc) settle_q <= settle_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  always_comb begin
    state_d    = state_q;
    dac_clr    = 1'b0;
    dac_step   = 1'b0;
    acc_clr    = 1'b0;
    acc_cap    = 1'b0;
    acc_add    = 1'b0;
    settle_clr = 1'b0;
    settle_inc = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          acc_clr    = 1'b1;
          dac_clr    = 1'b1;
          settle_clr = 1'b1;
          state_d    = ST_CNV;
        end
      end
      ST_CNV: begin
        if (!settled) begin
          settle_inc = 1'b1;   // let sync and code delay fill after clear
        end else if (!cmp_s || code_dly == CODE_MAX) begin
          acc_cap = 1'b1;
          state_d = ST_ACC;
        end else if (code != CODE_MAX) begin
          dac_step = 1'b1;
        end
      end
      ST_ACC: begin
        acc_add    = 1'b1;
        dac_clr    = 1'b1;
        settle_clr = 1'b1;
        state_d    = acc_last ? ST_IDLE : ST_CNV;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign dac_code_o = code;
endmodule

// File: rtl/ss_adc_avg_chk.sv
module ss_adc_avg_chk #(
  parameter int W = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] dac_i,
  input logic         done_i,
  input logic [W-1:0] avg_i,
  input logic [1:0]   state_i,
  input logic         last_i
);
  // R6: ramp only steps up by one or clears
  p_ramp_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_i != $past(dac_i)) |-> ((dac_i == $past(dac_i) + 1'b1) || (dac_i == '0)));

  // R6: DAC parked at zero when idle
  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0) |-> (dac_i == '0));

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R5: result only moves with done
  p_avg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(avg_i));

  // R3: done follows the accumulate step of the eighth sample
  p_done_eighth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(state_i) == 2'd2 && $past(last_i)));
endmodule

bind ss_adc_avg ss_adc_avg_chk #(.W(DAC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dac_i  (dac_code_o),
  .done_i (done_o),
  .avg_i  (avg_o),
  .state_i(state_q),
  .last_i (acc_last)
);

// File: tb/sim_ss_adc_avg.sv
module sim_ss_adc_avg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       cmp_hi_i;
  logic [9:0] dac_code_o;
  logic       done_o;
  logic [9:0] avg_o;

  int checks = 0;
  int errors = 0;

  // comparator model: per-conversion threshold
  logic [10:0] tgt_arr [8];
  int          falls = 0;
  int          base  = 0;
  int          step_err = 0;
  logic [9:0]  dac_prev = '0;
  logic [2:0]  conv_idx;

  assign conv_idx = 3'(falls - base);
  assign cmp_hi_i = ({1'b0, dac_code_o} < tgt_arr[conv_idx]);

  always #10 clk_i = ~clk_i;   // 50 MHz

  ss_adc_avg u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_hi_i  (cmp_hi_i),
    .dac_code_o(dac_code_o),
    .done_o    (done_o),
    .avg_o     (avg_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (dac_prev != 0 && dac_code_o == 0) falls++;
      if (dac_code_o != dac_prev && dac_code_o != 0 && dac_code_o != dac_prev + 10'd1)
        step_err++;
    end
    dac_prev = dac_code_o;
  end

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 190000) begin
      $display("FAIL watchdog: actual hung, expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_avg();
    int s = 0;
    for (int i = 0; i < 8; i++) s += (tgt_arr[i] > 11'd1023) ? 1023 : int'(tgt_arr[i]);
    return s >> 3;
  endfunction

  task automatic run_conv(input bit inj_start, input bit cnt_conv);
    int n = 0;
    int exp = exp_avg();
    int held;
    base = falls;
    @(negedge clk_i); #1;
    start_i = 1'b1;
    @(negedge clk_i); #1;
    start_i = 1'b0;
    while (!done_o && n < 12000) begin
      @(negedge clk_i); #1;
      n++;
      if (inj_start) start_i = (n == 40);   // R7: start while busy
    end
    start_i = 1'b0;
    if (!done_o) begin
      check("R5 done timeout", 0, 1);
      return;
    end
    check("R2/R4 average", int'(avg_o), exp);
    if (cnt_conv) check("R3 conversions", falls - base, 8);
    held = int'(avg_o);
    @(negedge clk_i); #1;
    check("R5 done width", int'(done_o), 0);
    check("R5 result held", int'(avg_o), held);
    check("R6 idle dac", int'(dac_code_o), 0);
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 8; i++) tgt_arr[i] = 11'(v);
  endtask

  initial begin
    fill(5);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 reset dac", int'(dac_code_o), 0);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset avg", int'(avg_o), 0);
    #1 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check("R1 post-reset avg", int'(avg_o), 0);

    // R2: comparator low at code 0
    fill(0);          run_conv(1'b0, 1'b0);
    // R2/R4: full scale, no overflow
    fill(1023);       run_conv(1'b0, 1'b1);
    // R2: never drops within range
    fill(1100);       run_conv(1'b0, 1'b1);
    // R4: truncation of remainder (sum 37 -> 4)
    tgt_arr = '{11'd1, 11'd2, 11'd3, 11'd4, 11'd5, 11'd6, 11'd7, 11'd9};
    run_conv(1'b0, 1'b1);
    // R7: start ignored mid-run
    tgt_arr = '{11'd100, 11'd37, 11'd250, 11'd3, 11'd77, 11'd400, 11'd12, 11'd90};
    run_conv(1'b1, 1'b1);

    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < 8; i++) tgt_arr[i] = 11'($urandom_range(1, 700));
      run_conv(r[0], 1'b1);
    end

    check("R6 ramp step", step_err, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule